// File: doc/BRIEF.md
# Two-Frame Remote Key Decoder

This block sits behind a pulse-level infrared receiver that has already turned bursts into 32-bit frame words. Each word arrives with a one-cycle valid strobe. The block checks a 4-bit checksum carried inside every word. It then pairs each accepted word with the word accepted just before it, because a key code is spread over two consecutive frames. When the two frames agree on a split sub-address, the block rebuilds a 32-bit scancode and reports either a fresh key press or a held-key repeat.

Only the fields needed from the previous frame are kept: its sub-address nibbles, its manufacturer byte and its address byte. A checksum failure discards that history. A word whose sub-address does not line up with the stored one replaces the history and produces no event. This lets a new address frame start a new pair. All outputs are registered. The event pulses appear in the cycle after the word was strobed in.

Top module: `rkey_pair_dec`

## Requirements
- R1: While rst_ni is low, and after it is released until the first event, every pulse output and oem_warn_o are 0, scancode_o is 0 and the stored history is all zero.
- R2: A strobed word is accepted only when its checksum nibble (bits 27:24) equals the low nibble of NOT(S + 0xF - checksum nibble), where S is the sum of all eight nibbles. Equivalently, the eight nibbles sum to 0 modulo 16.
- R3: A strobed word that fails the checksum raises csum_err_o, produces no keydown or repeat, and clears the stored history to zero.
- R4: For an accepted word, the stored sub-address is {history bits 31:28, history bits 23:20}. The current sub-address is {word bits 31:28, word bits 19:16}. If the two differ, there is no event and the word becomes the new history.
- R5: On an event, scancode_o = {history bits 7:0, current sub-address, word bits 15:8, word bits 7:0}. scancode_o changes at no other time.
- R6: On an event, a toggle nibble (word bits 23:20) of 0 gives a keydown_o pulse. Any other toggle value gives a repeat_o pulse.
- R7: On an event, oem_warn_o pulses with it when history bits 15:8 differ from 0x44. The event and scancode are still produced.
- R8: After every event, the current word becomes the stored history.
- R9: Each pulse lasts exactly one cycle and appears in the cycle after the strobe edge. At most one of keydown_o, repeat_o and csum_err_o is high. Back-to-back strobes are handled one per cycle.
- R10: A word presented with frame_vld_i low changes neither the outputs nor the stored history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 32 | Frame word from the pulse decoder |
| frame_vld_i | input | 1 | One-cycle strobe qualifying frame_i |
| scancode_o | output | 32 | Scancode of the last event |
| keydown_o | output | 1 | Key-press pulse |
| repeat_o | output | 1 | Held-key repeat pulse |
| csum_err_o | output | 1 | Checksum failure pulse |
| oem_warn_o | output | 1 | Unexpected manufacturer byte, pulsed with the event |

## Verification
The bench sends a word right after a checksum error whose sub-address is zero. A design that does not clear its history would pair that word with stale data and stay silent instead of reporting a key. A lone address word after reset must not pair with the zero history. A word presented without its strobe must not be taken as history; a design that latched it would emit a false key on the next word. Back-to-back strobes check that the pulse lands exactly one cycle late and drops after one cycle. Toggle and manufacturer-byte cases check that repeats and warnings are flagged without suppressing the scancode.

// File: rtl/rkey_pkg.sv
package rkey_pkg;
  localparam int NIB_W   = 4;
  localparam int FRAME_W = 32;
  localparam int NIB_N   = FRAME_W / NIB_W;
  localparam int BYTE_W  = 2 * NIB_W;
  localparam int CSUM_LSB = 24;

  typedef logic [FRAME_W-1:0] frame_t;
  typedef logic [NIB_W-1:0]   nib_t;
  typedef logic [BYTE_W-1:0]  byte_t;

  // field layout of an incoming word, msb first
  typedef struct packed {
    nib_t  sa_hi;
    nib_t  csum;
    nib_t  tog;
    nib_t  sa_lo;
    byte_t cmd_hi;
    byte_t cmd_lo;
  } frame_f_t;

  // only what the next frame needs from this one
  typedef struct packed {
    nib_t  sa_hi;
    nib_t  sa_lo;
    byte_t oem;
    byte_t addr;
  } hist_t;
endpackage

// File: rtl/rkey_csum.sv
module rkey_csum
  import rkey_pkg::*;
(
  input  frame_t frame_i,
  output logic   ok_o
);
  localparam int SUM_W = NIB_W + $clog2(NIB_N) + 1;

  nib_t             nib [NIB_N];
  logic [SUM_W-1:0] sum;
  nib_t             stored;
  nib_t             calc;

  for (genvar i = 0; i < NIB_N; i++) begin : g_nib
    assign nib[i] = frame_i[i*NIB_W +: NIB_W];
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < NIB_N; i++) sum = sum + SUM_W'(nib[i]);
  end

  assign stored = frame_i[CSUM_LSB +: NIB_W];
  assign calc   = NIB_W'(~(sum + SUM_W'({NIB_W{1'b1}}) - SUM_W'(stored)));
  assign ok_o   = (calc == stored);
endmodule

// File: rtl/rkey_pair.sv
module rkey_pair
  import rkey_pkg::*;
#(
  parameter byte_t OEM_CODE = 8'h44
) (
  input  hist_t               prev_i,
  input  nib_t                sa_hi_i,
  input  nib_t                sa_lo_i,
  input  nib_t                tog_i,
  input  logic [2*BYTE_W-1:0] cmd_i,
  output logic                match_o,
  output logic                key_o,
  output logic                oem_bad_o,
  output frame_t              scan_o
);
  byte_t sub_prev, sub_cur;

  assign sub_prev  = {prev_i.sa_hi, prev_i.sa_lo};
  assign sub_cur   = {sa_hi_i, sa_lo_i};
  assign match_o   = (sub_prev == sub_cur);
  assign key_o     = (tog_i == '0);
  assign oem_bad_o = (prev_i.oem != OEM_CODE);
  assign scan_o    = {prev_i.addr, sub_cur, cmd_i};
endmodule

// File: rtl/rkey_hist.sv
module rkey_hist
  import rkey_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  logic  clear_i,
  input  hist_t d_i,
  output hist_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (clear_i) q_o <= '0;
    else if (load_i)  q_o <= d_i;
  end
endmodule

// File: rtl/rkey_pair_dec.sv
module rkey_pair_dec
  import rkey_pkg::*;
#(
  parameter byte_t OEM_CODE = 8'h44
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] frame_i,
  input  logic        frame_vld_i,
  output logic [31:0] scancode_o,
  output logic        keydown_o,
  output logic        repeat_o,
  output logic        csum_err_o,
  output logic        oem_warn_o
);
  frame_f_t cur;
  hist_t    prev_q, prev_d;
  logic     csum_ok, match, key, oem_bad;
  frame_t   scan_w;

  assign cur    = frame_i;
  assign prev_d = '{sa_hi: cur.sa_hi, sa_lo: cur.tog, oem: cur.cmd_hi, addr: cur.cmd_lo};

  rkey_csum u_csum (
    .frame_i (frame_i),
    .ok_o    (csum_ok)
  );

  rkey_pair #(.OEM_CODE(OEM_CODE)) u_pair (
    .prev_i    (prev_q),
    .sa_hi_i   (cur.sa_hi),
    .sa_lo_i   (cur.sa_lo),
    .tog_i     (cur.tog),
    .cmd_i     ({cur.cmd_hi, cur.cmd_lo}),
    .match_o   (match),
    .key_o     (key),
    .oem_bad_o (oem_bad),
    .scan_o    (scan_w)
  );

  // every accepted word becomes history, matched or not
  rkey_hist u_hist (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (frame_vld_i & csum_ok),
    .clear_i (frame_vld_i & ~csum_ok),
    .d_i     (prev_d),
    .q_o     (prev_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scancode_o <= '0;
      keydown_o  <= 1'b0;
      repeat_o   <= 1'b0;
      csum_err_o <= 1'b0;
      oem_warn_o <= 1'b0;
    end else begin
      keydown_o  <= 1'b0;
      repeat_o   <= 1'b0;
      csum_err_o <= 1'b0;
      oem_warn_o <= 1'b0;
      if (frame_vld_i) begin
        if (!csum_ok) begin
          csum_err_o <= 1'b1;
        end else if (match) begin
          keydown_o  <= key;
          repeat_o   <= ~key;
          oem_warn_o <= oem_bad;
          scancode_o <= scan_w;
        end
      end
    end
  end
endmodule

// File: rtl/rkey_pair_dec_chk.sv
module rkey_pair_dec_chk
  import rkey_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] frame_i,
  input logic        frame_vld_i,
  input logic [31:0] scancode_o,
  input logic        keydown_o,
  input logic        repeat_o,
  input logic        csum_err_o,
  input logic        oem_warn_o,
  input hist_t       prev_i
);
  nib_t nib_mod;
  logic ev;

  always_comb begin
    nib_mod = '0;
    for (int i = 0; i < NIB_N; i++) nib_mod = nib_mod + frame_i[i*NIB_W +: NIB_W];
  end

  assign ev = keydown_o | repeat_o;

  AST_CSUM_RULE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_i |=> (csum_err_o == ($past(nib_mod) != '0)));  // R2
  AST_ERR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csum_err_o |-> (prev_i == '0));  // R3
  AST_SCAN_SUBADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev |-> (scancode_o[23:16] == {$past(frame_i[31:28]), $past(frame_i[19:16])}));  // R4
  AST_TOGGLE_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    keydown_o |-> ($past(frame_i[23:20]) == '0));  // R6
  AST_TOGGLE_REP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    repeat_o |-> ($past(frame_i[23:20]) != '0));  // R6
  AST_WARN_WITH_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oem_warn_o |-> ev);  // R7
  AST_EVENT_STORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev |-> (prev_i.sa_hi == $past(frame_i[31:28]) && prev_i.addr == $past(frame_i[7:0])));  // R8
  AST_ONE_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({keydown_o, repeat_o, csum_err_o}));  // R9
  AST_SCAN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ev |-> $stable(scancode_o));  // R5
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev | csum_err_o) |-> $past(frame_vld_i));  // R10
endmodule

bind rkey_pair_dec rkey_pair_dec_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .frame_i     (frame_i),
  .frame_vld_i (frame_vld_i),
  .scancode_o  (scancode_o),
  .keydown_o   (keydown_o),
  .repeat_o    (repeat_o),
  .csum_err_o  (csum_err_o),
  .oem_warn_o  (oem_warn_o),
  .prev_i      (prev_q)
);

// File: tb/rkey_pair_dec_bench.sv
`timescale 1ns/1ps
module rkey_pair_dec_bench;
  localparam logic [1:0] K_NONE = 2'd0, K_KEY = 2'd1, K_REP = 2'd2, K_ERR = 2'd3;

  typedef struct packed {
    logic [31:0] frame;   // checksum nibble filled in by seal()
    logic        bad;
    logic [1:0]  kind;
    logic        warn;
    logic [31:0] scan;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{32'h30C1445A, 1'b0, K_NONE, 1'b0, 32'h00000000},  // R4 zero history, no pair
    '{32'h300C1234, 1'b0, K_KEY,  1'b0, 32'h5A3C1234},  // R5 R6 pair -> key
    '{32'h30C1445A, 1'b0, K_NONE, 1'b0, 32'h5A3C1234},  // R4 mismatch, becomes history
    '{32'h301C1234, 1'b0, K_REP,  1'b0, 32'h5A3C1234},  // R6 toggle 1 -> repeat
    '{32'h70214509, 1'b0, K_NONE, 1'b0, 32'h5A3C1234},  // R4
    '{32'h7002ABCD, 1'b0, K_KEY,  1'b1, 32'h0972ABCD},  // R7 oem 0x45
    '{32'h7002ABCD, 1'b1, K_ERR,  1'b0, 32'h0972ABCD},  // R3 bad checksum
    '{32'h00001122, 1'b0, K_KEY,  1'b1, 32'h00001122},  // R3 history cleared
    '{32'h00501122, 1'b0, K_REP,  1'b1, 32'h22001122}   // R8 previous word kept
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] frame_i = '0;
  logic        frame_vld_i = 1'b0;
  logic [31:0] scancode_o;
  logic        keydown_o, repeat_o, csum_err_o, oem_warn_o;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  rkey_pair_dec u_rkey_pair_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_i     (frame_i),
    .frame_vld_i (frame_vld_i),
    .scancode_o  (scancode_o),
    .keydown_o   (keydown_o),
    .repeat_o    (repeat_o),
    .csum_err_o  (csum_err_o),
    .oem_warn_o  (oem_warn_o)
  );

  // all eight nibbles must sum to 0 mod 16
  function automatic logic [31:0] seal(logic [31:0] f, logic bad);
    logic [3:0] s = '0;
    for (int i = 0; i < 8; i++) if (i != 6) s = s + f[i*4 +: 4];
    s = 4'(-s) + {3'b0, bad};
    return {f[31:28], s, f[23:0]};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_out(string tag, logic [1:0] kind, logic warn, logic [31:0] scan);
    check({tag, " R6 keydown"}, 32'(keydown_o), 32'(kind == K_KEY));
    check({tag, " R6 repeat"},  32'(repeat_o),  32'(kind == K_REP));
    check({tag, " R3 csum_err"}, 32'(csum_err_o), 32'(kind == K_ERR));
    check({tag, " R7 oem_warn"}, 32'(oem_warn_o), 32'(warn));
    check({tag, " R5 scancode"}, scancode_o, scan);
  endtask

  task automatic send(logic [31:0] f);
    @(negedge clk_i);
    frame_i = f;
    frame_vld_i = 1'b1;
    @(negedge clk_i);
    frame_vld_i = 1'b0;
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check_out("R1 in reset", K_NONE, 1'b0, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_out("R1 after reset", K_NONE, 1'b0, 32'h0);

    for (int v = 0; v < NV; v++) begin
      send(seal(VEC[v].frame, VEC[v].bad));
      check_out($sformatf("vec%0d", v), VEC[v].kind, VEC[v].warn, VEC[v].scan);
    end

    // R10: unstrobed word must not become history
    @(negedge clk_i);
    frame_i = seal(32'h30C1445A, 1'b0);
    @(negedge clk_i);
    check_out("R10 unstrobed", K_NONE, 1'b0, 32'h22001122);
    send(seal(32'h300C1234, 1'b0));
    check_out("R10 no false pair", K_NONE, 1'b0, 32'h22001122);

    // R1: reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check_out("R1 reset again", K_NONE, 1'b0, 32'h0);
    rst_ni = 1'b1;

    // R9: back-to-back strobes
    @(negedge clk_i);
    frame_i = seal(32'h30C1445A, 1'b0);
    frame_vld_i = 1'b1;
    @(negedge clk_i);
    frame_i = seal(32'h300C1234, 1'b0);
    check_out("R4 first of pair", K_NONE, 1'b0, 32'h0);
    @(negedge clk_i);
    frame_vld_i = 1'b0;
    check_out("R9 back-to-back", K_KEY, 1'b0, 32'h5A3C1234);
    @(negedge clk_i);
    check_out("R9 pulse width", K_NONE, 1'b0, 32'h5A3C1234);

    // R8: event word becomes history and pairs with the next word
    send(seal(32'h30700F0E, 1'b0));
    check_out("R8 chained", K_REP, 1'b1, 32'h34300F0E);

    // R2: nibble sum wrapping many times still accepted
    send(seal(32'hF0FFFFFF, 1'b0));
    check_out("R2 wrap accepted", K_NONE, 1'b0, 32'h34300F0E);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule